// File: doc/BRIEF.md
# JTAG Router Bring-Up Sequencer

This block drives the command port of a JTAG TAP shifter through the fixed handshake that exposes a debug port hidden behind an on-chip JTAG router with a 6-bit instruction register. After a start pulse it connects to the router and writes each word of a parameter table into the router through its indirect 32-bit data register. It can read every write back to confirm it. It then parks the router in bypass and lets the chain change settle with idle clocks. When the sequence ends or aborts it reports done, pass, a failure code and the table index that failed.

Each step is one command on a valid/ready stream toward the TAP shifter. The shifter answers every command, including IR shifts and idle runs, with one word of captured TDO bits on a valid/ready response stream. Only one command is outstanding at a time. The sequencer raises `rsp_ready` only while it waits for the answer to the command it just issued. The shifter may stall either side for any number of cycles. A command once offered holds its fields until it is accepted.

Top module: `jtag_router_bringup`

## Requirements
- R1: After reset `busy`, `done`, `cmd_valid`, `rsp_ready`, `pass` are 0, `fail_code` is 0 and `fail_idx` is 0.
- R2: A `start` pulse while idle latches `verify_en`, and in the next cycle `busy` is 1 and the first command is offered. That command is an IR shift (`cmd_kind` 0) of 6 bits with data 0x07.
- R3: A command holds `cmd_kind`, `cmd_len` and `cmd_data` stable while `cmd_valid` is 1 and `cmd_ready` is 0. After acceptance `cmd_valid` stays 0 and `rsp_ready` is 1 until one response is accepted, and `cmd_valid` and `rsp_ready` are never 1 together.
- R4: The second command is a DR shift (`cmd_kind` 1) of 8 bits with data 0x89. With verification on, it is followed by an 8-bit DR shift of 0x00. The low 8 bits of that answer must equal 0x09, or the run ends with `fail_code` 1.
- R5: The router IR value 0x02 is loaded with a 6-bit IR shift. Then each table entry, index 0 first, is shifted as a 32-bit DR value with bit 31 set to 1. The default entries are 0x60002000 and 0x2C002100.
- R6: With verification on, each entry write is followed by a 32-bit DR shift of zeros. Bits 31:24 of the answer must equal bits 31:24 of the unmodified entry, or the run ends with `fail_code` 2 and `fail_idx` set to the entry index.
- R7: The run closes with a 6-bit IR shift of 0x3F, then an idle run (`cmd_kind` 2) with `cmd_len` 16. Its answer ends the run with `pass` 1 and `fail_code` 0.
- R8: With verification off, no readback command is issued. The stream is IR 0x07, DR 0x89, IR 0x02, one write per entry, IR 0x3F and the idle run.
- R9: A `start` pulse or a change of `verify_en` while `busy` is 1 leaves the command stream and the result unchanged.
- R10: `done` is a one-cycle pulse in the cycle after the final response is accepted, with `busy` 0. After a failure no further command is issued. `pass`, `fail_code` and `fail_idx` hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| verify_en | input | 1 | Enables readback checks; latched at start |
| cmd_valid | output | 1 | Command offered to the TAP shifter |
| cmd_ready | input | 1 | TAP shifter accepts the command |
| cmd_kind | output | 2 | 0 IR shift, 1 DR shift, 2 idle run |
| cmd_len | output | LEN_W (6) | Bits to shift or idle cycles to run |
| cmd_data | output | DATA_W (32) | Bits to shift, bit 0 first |
| rsp_valid | input | 1 | Captured bits available |
| rsp_ready | output | 1 | Sequencer takes the response |
| rsp_data | input | DATA_W (32) | Captured TDO bits, bit 0 first shifted |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Last run completed without failure |
| fail_code | output | 2 | 0 none, 1 connect, 2 write |
| fail_idx | output | IDX_W (1) | Entry index of a write failure |

## Verification
The first command is due on the cycle after the start pulse. Every later command is due on the cycle after the previous response is accepted. `done` and the result fields are due on the cycle after the last response is accepted. The bench samples on the falling edge. It waits for `cmd_valid` before comparing a command's fields, and it samples `done` exactly one falling edge after the final response handshake. It also confirms that `cmd_valid` stays low in every cycle between an accepted command and its response.

// File: rtl/jrb_pkg.sv
package jrb_pkg;

  typedef enum logic [1:0] {
    OP_IR_SHIFT = 2'd0,
    OP_DR_SHIFT = 2'd1,
    OP_IDLE_RUN = 2'd2
  } tap_op_e;

  typedef enum logic [1:0] {
    RES_OK         = 2'd0,
    RES_CONNECT_NG = 2'd1,
    RES_WRITE_NG   = 2'd2
  } result_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_IR_CONNECT,
    ST_DR_CONNECT,
    ST_RD_CONNECT,
    ST_IR_ROUTER,
    ST_DR_WRITE,
    ST_RD_WRITE,
    ST_IR_BYPASS,
    ST_SETTLE
  } step_e;

endpackage

// File: rtl/jrb_entry_rom.sv
module jrb_entry_rom #(
  parameter int unsigned N_ENTRIES = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_W     = 1,
  parameter logic [N_ENTRIES*DATA_W-1:0] TABLE = '0
) (
  input  logic [IDX_W-1:0]  sel,
  output logic [DATA_W-1:0] word
);

  logic [DATA_W-1:0] slot [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    assign slot[g] = TABLE[g*DATA_W +: DATA_W];
  end

  always_comb begin
    word = slot[0];
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (sel == IDX_W'(i)) word = slot[i];
    end
  end

endmodule

// File: rtl/jrb_cmd_gen.sv
module jrb_cmd_gen
  import jrb_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned LEN_W        = 6,
  parameter int unsigned IR_LEN       = 6,
  parameter int unsigned CONNECT_LEN  = 8,
  parameter int unsigned IDLE_CYCLES  = 16,
  parameter logic [IR_LEN-1:0]      IR_BYPASS    = '1,
  parameter logic [IR_LEN-1:0]      IR_CONNECT   = 6'h07,
  parameter logic [IR_LEN-1:0]      IR_ROUTER    = 6'h02,
  parameter logic [CONNECT_LEN-1:0] CONNECT_WORD = 8'h89
) (
  input  step_e             step,
  input  logic [DATA_W-1:0] entry,
  output tap_op_e           op,
  output logic [LEN_W-1:0]  len,
  output logic [DATA_W-1:0] data
);

  localparam logic [LEN_W-1:0] L_IR   = LEN_W'(IR_LEN);
  localparam logic [LEN_W-1:0] L_CONN = LEN_W'(CONNECT_LEN);
  localparam logic [LEN_W-1:0] L_WORD = LEN_W'(DATA_W);
  localparam logic [LEN_W-1:0] L_IDLE = LEN_W'(IDLE_CYCLES);

  logic [DATA_W-1:0] forced_entry;
  assign forced_entry = {1'b1, entry[DATA_W-2:0]};

  always_comb begin
    op   = OP_IR_SHIFT;
    len  = L_IR;
    data = '0;
    unique case (step)
      ST_IR_CONNECT: data = DATA_W'(IR_CONNECT);
      ST_IR_ROUTER:  data = DATA_W'(IR_ROUTER);
      ST_IR_BYPASS:  data = DATA_W'(IR_BYPASS);
      ST_DR_CONNECT: begin
        op   = OP_DR_SHIFT;
        len  = L_CONN;
        data = DATA_W'(CONNECT_WORD);
      end
      ST_RD_CONNECT: begin
        op  = OP_DR_SHIFT;
        len = L_CONN;
      end
      ST_DR_WRITE: begin
        op   = OP_DR_SHIFT;
        len  = L_WORD;
        data = forced_entry;
      end
      ST_RD_WRITE: begin
        op  = OP_DR_SHIFT;
        len = L_WORD;
      end
      ST_SETTLE: begin
        op  = OP_IDLE_RUN;
        len = L_IDLE;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/jrb_rsp_check.sv
module jrb_rsp_check
  import jrb_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CONNECT_LEN = 8,
  parameter int unsigned CHECK_BITS  = 8,
  parameter logic [CONNECT_LEN-1:0] CONNECT_EXPECT = 8'h09
) (
  input  step_e             step,
  input  logic [DATA_W-1:0] entry,
  input  logic [DATA_W-1:0] captured,
  output logic              match
);

  logic conn_ok;
  logic wr_ok;

  assign conn_ok = captured[CONNECT_LEN-1:0] == CONNECT_EXPECT;
  assign wr_ok   = captured[DATA_W-1 -: CHECK_BITS] == entry[DATA_W-1 -: CHECK_BITS];

  always_comb begin
    unique case (step)
      ST_RD_CONNECT: match = conn_ok;
      ST_RD_WRITE:   match = wr_ok;
      default:       match = 1'b1;
    endcase
  end

endmodule

// File: rtl/jrb_ctrl.sv
module jrb_ctrl
  import jrb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 2,
  parameter int unsigned IDX_W     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             verify_en,
  input  logic             cmd_ready,
  input  logic             rsp_valid,
  input  logic             rsp_match,
  output step_e            step,
  output logic [IDX_W-1:0] idx,
  output logic             cmd_valid,
  output logic             rsp_ready,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output result_e          fail_code,
  output logic [IDX_W-1:0] fail_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

  logic    waiting;
  logic    verify_q;
  step_e   step_nxt;
  logic    idx_adv;
  logic    finish;
  result_e finish_code;
  logic    last_entry;
  logic    cmd_fire;
  logic    rsp_fire;

  assign busy       = step != ST_IDLE;
  assign cmd_valid  = busy && !waiting;
  assign rsp_ready  = busy && waiting;
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign rsp_fire   = rsp_ready && rsp_valid;
  assign last_entry = idx == LAST_IDX;

  always_comb begin
    step_nxt    = step;
    idx_adv     = 1'b0;
    finish      = 1'b0;
    finish_code = RES_OK;
    unique case (step)
      ST_IR_CONNECT: step_nxt = ST_DR_CONNECT;
      ST_DR_CONNECT: step_nxt = verify_q ? ST_RD_CONNECT : ST_IR_ROUTER;
      ST_RD_CONNECT: begin
        if (rsp_match) begin
          step_nxt = ST_IR_ROUTER;
        end else begin
          step_nxt    = ST_IDLE;
          finish      = 1'b1;
          finish_code = RES_CONNECT_NG;
        end
      end
      ST_IR_ROUTER: step_nxt = ST_DR_WRITE;
      ST_DR_WRITE: begin
        if (verify_q) begin
          step_nxt = ST_RD_WRITE;
        end else if (last_entry) begin
          step_nxt = ST_IR_BYPASS;
        end else begin
          step_nxt = ST_DR_WRITE;
          idx_adv  = 1'b1;
        end
      end
      ST_RD_WRITE: begin
        if (!rsp_match) begin
          step_nxt    = ST_IDLE;
          finish      = 1'b1;
          finish_code = RES_WRITE_NG;
        end else if (last_entry) begin
          step_nxt = ST_IR_BYPASS;
        end else begin
          step_nxt = ST_DR_WRITE;
          idx_adv  = 1'b1;
        end
      end
      ST_IR_BYPASS: step_nxt = ST_SETTLE;
      ST_SETTLE: begin
        step_nxt = ST_IDLE;
        finish   = 1'b1;
      end
      default: step_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step      <= ST_IDLE;
      idx       <= '0;
      waiting   <= 1'b0;
      verify_q  <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail_code <= RES_OK;
      fail_idx  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          step      <= ST_IR_CONNECT;
          idx       <= '0;
          waiting   <= 1'b0;
          verify_q  <= verify_en;
          pass      <= 1'b0;
          fail_code <= RES_OK;
          fail_idx  <= '0;
        end
      end else if (cmd_fire) begin
        waiting <= 1'b1;
      end else if (rsp_fire) begin
        waiting <= 1'b0;
        step    <= step_nxt;
        if (idx_adv) idx <= idx + 1'b1;
        if (finish) begin
          done      <= 1'b1;
          pass      <= finish_code == RES_OK;
          fail_code <= finish_code;
          fail_idx  <= (finish_code == RES_WRITE_NG) ? idx : '0;
        end
      end
    end
  end

endmodule

// File: rtl/jtag_router_bringup.sv
module jtag_router_bringup
  import jrb_pkg::*;
#(
  parameter int unsigned N_ENTRIES   = 2,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned IR_LEN      = 6,
  parameter int unsigned CONNECT_LEN = 8,
  parameter int unsigned CHECK_BITS  = 8,
  parameter int unsigned IDLE_CYCLES = 16,
  parameter logic [IR_LEN-1:0]      IR_BYPASS      = '1,
  parameter logic [IR_LEN-1:0]      IR_CONNECT     = 6'h07,
  parameter logic [IR_LEN-1:0]      IR_ROUTER      = 6'h02,
  parameter logic [CONNECT_LEN-1:0] CONNECT_WORD   = 8'h89,
  parameter logic [CONNECT_LEN-1:0] CONNECT_EXPECT = 8'h09,
  parameter logic [N_ENTRIES*DATA_W-1:0] ENTRY_TABLE = {32'h2C002100, 32'h60002000},
  localparam int unsigned MAX_A = (DATA_W > IDLE_CYCLES) ? DATA_W : IDLE_CYCLES,
  localparam int unsigned MAX_B = (IR_LEN > CONNECT_LEN) ? IR_LEN : CONNECT_LEN,
  localparam int unsigned MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int unsigned LEN_W = $clog2(MAX_LEN + 1),
  localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              verify_en,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [1:0]        fail_code,
  output logic [IDX_W-1:0]  fail_idx
);

  step_e             step;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] entry;
  logic              rsp_match;
  tap_op_e           op;
  result_e           code;

  assign cmd_kind  = op;
  assign fail_code = code;

  jrb_entry_rom #(
    .N_ENTRIES (N_ENTRIES),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .TABLE     (ENTRY_TABLE)
  ) u_rom (
    .sel  (idx),
    .word (entry)
  );

  jrb_cmd_gen #(
    .DATA_W       (DATA_W),
    .LEN_W        (LEN_W),
    .IR_LEN       (IR_LEN),
    .CONNECT_LEN  (CONNECT_LEN),
    .IDLE_CYCLES  (IDLE_CYCLES),
    .IR_BYPASS    (IR_BYPASS),
    .IR_CONNECT   (IR_CONNECT),
    .IR_ROUTER    (IR_ROUTER),
    .CONNECT_WORD (CONNECT_WORD)
  ) u_gen (
    .step  (step),
    .entry (entry),
    .op    (op),
    .len   (cmd_len),
    .data  (cmd_data)
  );

  jrb_rsp_check #(
    .DATA_W         (DATA_W),
    .CONNECT_LEN    (CONNECT_LEN),
    .CHECK_BITS     (CHECK_BITS),
    .CONNECT_EXPECT (CONNECT_EXPECT)
  ) u_chk (
    .step     (step),
    .entry    (entry),
    .captured (rsp_data),
    .match    (rsp_match)
  );

  jrb_ctrl #(
    .N_ENTRIES (N_ENTRIES),
    .IDX_W     (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .verify_en (verify_en),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_match (rsp_match),
    .step      (step),
    .idx       (idx),
    .cmd_valid (cmd_valid),
    .rsp_ready (rsp_ready),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .fail_code (code),
    .fail_idx  (fail_idx)
  );

endmodule

// File: rtl/jrb_sva.sv
module jrb_sva #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_kind,
  input logic [LEN_W-1:0]  cmd_len,
  input logic [DATA_W-1:0] cmd_data,
  input logic              rsp_ready,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [1:0]        fail_code
);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_len) && $stable(cmd_data)); // R3

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !rsp_ready); // R3

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R2

  AST_WRITE_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind == 2'd1 && cmd_len == LEN_W'(DATA_W) && cmd_data != '0 |-> cmd_data[DATA_W-1]); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !cmd_valid); // R10

  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done && pass |-> fail_code == 2'd0); // R7

endmodule

bind jtag_router_bringup jrb_sva #(
  .DATA_W (DATA_W),
  .LEN_W  (LEN_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_kind  (cmd_kind),
  .cmd_len   (cmd_len),
  .cmd_data  (cmd_data),
  .rsp_ready (rsp_ready),
  .busy      (busy),
  .done      (done),
  .pass      (pass),
  .fail_code (fail_code)
);

// File: tb/test_jtag_router_bringup.sv
module test_jtag_router_bringup;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        verify_en = 1'b0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [1:0]  cmd_kind;
  logic [5:0]  cmd_len;
  logic [31:0] cmd_data;
  logic        rsp_valid = 1'b0;
  logic        rsp_ready;
  logic [31:0] rsp_data = '0;
  logic        busy;
  logic        done;
  logic        pass;
  logic [1:0]  fail_code;
  logic [0:0]  fail_idx;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  jtag_router_bringup i_jtag_router_bringup (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .verify_en (verify_en),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_kind  (cmd_kind),
    .cmd_len   (cmd_len),
    .cmd_data  (cmd_data),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .fail_code (fail_code),
    .fail_idx  (fail_idx)
  );

  logic [31:0] table_w [2] = '{32'h60002000, 32'h2C002100};

  logic [1:0]  e_kind [16];
  logic [5:0]  e_len  [16];
  logic [31:0] e_data [16];
  logic [31:0] e_rsp  [16];
  string       e_tag  [16];
  int          n_cmd;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [5:0] l, input logic [31:0] d,
                      input logic [31:0] r, input string t);
    e_kind[n_cmd] = k;
    e_len[n_cmd]  = l;
    e_data[n_cmd] = d;
    e_rsp[n_cmd]  = r;
    e_tag[n_cmd]  = t;
    n_cmd++;
  endtask

  // bad_at: -1 none, 0 connect readback, k+1 readback of entry k
  task automatic build(input bit ver, input int bad_at);
    logic [31:0] r;
    n_cmd = 0;
    push(2'd0, 6'd6, 32'h07, $urandom, "R2");
    push(2'd1, 6'd8, 32'h89, $urandom, ver ? "R4" : "R8");
    if (ver) begin
      r = {$urandom, 8'h09};
      r = {r[31:8], 8'h09};
      if (bad_at == 0) r = r ^ (32'd1 << ($urandom % 8));
      push(2'd1, 6'd8, 32'h0, r, "R4");
      if (bad_at == 0) return;
    end
    push(2'd0, 6'd6, 32'h02, $urandom, ver ? "R5" : "R8");
    for (int k = 0; k < 2; k++) begin
      push(2'd1, 6'd32, table_w[k] | 32'h80000000, $urandom, ver ? "R5" : "R8");
      if (ver) begin
        r = $urandom;
        r = {table_w[k][31:24], r[23:0]};
        if (bad_at == k + 1) r = r ^ (32'd1 << (24 + ($urandom % 8)));
        push(2'd1, 6'd32, 32'h0, r, "R6");
        if (bad_at == k + 1) return;
      end
    end
    push(2'd0, 6'd6, 32'h3F, $urandom, ver ? "R7" : "R8");
    push(2'd2, 6'd16, 32'h0, $urandom, ver ? "R7" : "R8");
  endtask

  task automatic run_case(input bit ver, input int bad_at, input bit poke);
    int          cyc;
    int          stall;
    int          gap;
    logic [1:0]  exp_code;
    logic [0:0]  exp_idx;
    build(ver, bad_at);
    exp_code = (ver && bad_at == 0) ? 2'd1 : (ver && bad_at > 0) ? 2'd2 : 2'd0;
    exp_idx  = (ver && bad_at > 0) ? 1'(bad_at - 1) : 1'b0;

    start = 1'b1;
    verify_en = ver;
    @(negedge clk);
    start = 1'b0;
    chk(busy && cmd_valid, "R2 busy and first command", {30'd0, busy, cmd_valid}, 32'd3);

    for (int j = 0; j < n_cmd; j++) begin
      cyc = 0;
      while (!cmd_valid && cyc < 50) begin
        @(negedge clk);
        cyc++;
      end
      stall = $urandom % 3;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(cmd_valid && cmd_data == e_data[j] && cmd_len == e_len[j], "R3 hold while stalled",
            cmd_data, e_data[j]);
      end
      chk(cmd_valid && cmd_kind == e_kind[j], {e_tag[j], " kind"}, {30'd0, cmd_kind}, {30'd0, e_kind[j]});
      chk(cmd_len == e_len[j], {e_tag[j], " len"}, {26'd0, cmd_len}, {26'd0, e_len[j]});
      chk(cmd_data == e_data[j], {e_tag[j], " data"}, cmd_data, e_data[j]);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      chk(!cmd_valid && rsp_ready, "R3 waiting for response", {30'd0, cmd_valid, rsp_ready}, 32'd1);
      gap = $urandom % 3;
      for (int s = 0; s < gap; s++) begin
        if (poke && j == 3 && s == 0) begin
          start = 1'b1;
          verify_en = ~ver;
        end
        @(negedge clk);
        start = 1'b0;
        chk(!cmd_valid, "R3 no command before response", {31'd0, cmd_valid}, 32'd0);
      end
      rsp_valid = 1'b1;
      rsp_data = e_rsp[j];
      @(negedge clk);
      rsp_valid = 1'b0;
      verify_en = ver;
      if (j == n_cmd - 1) begin
        chk(done && !busy, "R10 done pulse", {30'd0, done, busy}, 32'd2);
        chk(pass == (exp_code == 2'd0), exp_code == 2'd0 ? "R7 pass" : "R10 pass low",
            {31'd0, pass}, {31'd0, exp_code == 2'd0});
        chk(fail_code == exp_code, exp_code == 2'd1 ? "R4 fail code" : exp_code == 2'd2 ? "R6 fail code" : "R7 code",
            {30'd0, fail_code}, {30'd0, exp_code});
        chk(fail_idx == exp_idx, "R6 fail index", {31'd0, fail_idx}, {31'd0, exp_idx});
      end else begin
        chk(!done && busy, "R10 no early done", {30'd0, done, busy}, 32'd1);
      end
    end
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk(!done && !cmd_valid && !busy, poke ? "R9 single run" : "R10 quiet after done",
          {29'd0, done, cmd_valid, busy}, 32'd0);
    end
    chk(fail_code == exp_code && pass == (exp_code == 2'd0), "R10 result held",
        {29'd0, pass, fail_code}, {29'd0, exp_code == 2'd0, exp_code});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cmd_valid && !rsp_ready && !pass && fail_code == 0 && fail_idx == 0,
        "R1 reset state", {26'd0, busy, done, cmd_valid, rsp_ready, pass, fail_idx}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_case(1'b1, -1, 1'b0);
    run_case(1'b0, -1, 1'b0);
    run_case(1'b1, 0, 1'b0);
    run_case(1'b1, 1, 1'b0);
    run_case(1'b1, 2, 1'b1);
    run_case(1'b0, 1, 1'b1);
    // random mix
    for (int i = 0; i < 24; i++) begin
      run_case(1'($urandom % 2), int'($urandom % 4) - 1, 1'($urandom % 2));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule